// File: doc/BRIEF.md
# Link and Duplex Resolution Checker

This block runs one link check for the primary transceiver each time it is started. It issues register reads through an external management-bus master and watches the returned status word for two conditions: a missing transceiver, and a link that is down. If neither applies, it works out the duplex and speed from the link partner's abilities and the local advertisement. The result is held in a two-bit mode register made of a full-duplex bit and a transmit-threshold bit.

The surrounding controller pulses `start` on a periodic tick. It supplies the advertisement word and a lock flag that forces full duplex. The block talks to the management master through a request/response pair. Each finished check ends with a one-cycle `done` pulse carrying a two-bit result code. When the mode register takes a new value, a `restart` pulse tells the datapath to restart its transmit and receive engines. The serial management signalling itself lives in the master and is not part of this block.

Top module: `ldr_link_check`

## Requirements
- R1: After reset both mode bits are 0, and `done`, `restart` and `req_valid` are low.
- R2: A `start` in idle issues a read of register 1 (status), then a read of register 5 (partner abilities). Each request holds `req_valid` and `req_reg` until the cycle in which `rsp_valid` is high.
- R3: If the first status word is 0xFFFF, the code is 3 (missing). The mode is left unchanged, `restart` stays low and no further status read is issued.
- R4: If bit 2 (link) of the first status word is 0, register 1 is read a second time. If bit 2 is still 0, the code is 2 (no link) and the mode is left unchanged.
- R5: If the second status read shows bit 2 set, resolution proceeds using the partner word from the earlier read.
- R6: The negotiated set is the partner word ANDed with the advertisement. The threshold bit becomes 0 if the set contains any of bits 7, 8 or 9 (100 Mb/s abilities), and 1 otherwise.
- R7: The full-duplex bit becomes 1 when the lock flag is set. Otherwise it becomes 1 when negotiated bit 8 is set, or when bit 6 is set and bit 7 is clear. In all other cases it becomes 0.
- R8: If the resolved mode differs from the stored mode, the mode is updated, `restart` pulses in the `done` cycle and the code is 1 (changed). If they are equal, the code is 0 (ok) and there is no `restart`.
- R9: `done` is a one-cycle pulse, and `status` is valid during it. A `start` that arrives while a check is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one check |
| adv_word | input | 16 | Local advertisement word |
| dplx_lock | input | 1 | Force full duplex |
| req_valid | output | 1 | Read request to the management master |
| req_reg | output | 5 | Register address of the request |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 16 | Returned register word |
| done | output | 1 | Check finished |
| status | output | 2 | Result code: 0 ok, 1 changed, 2 no link, 3 missing |
| mode_fdx | output | 1 | Full-duplex mode bit |
| mode_thr | output | 1 | Transmit-threshold mode bit |
| restart | output | 1 | Pulse when the mode changed |

## Verification
The bench covers a link that is down on the first status read but up on the second. A design that trusts the first read would report no link and drop the update. It also covers a link that stays down: a design with no retry shows one status read instead of two, and a design that still resolves changes the mode. The partner patterns set 10 Mb/s full duplex with and without 100 Mb/s half duplex, and also 100 Mb/s T4 only. These catch a wrong duplex rule or a missing 100 Mb/s bit in the threshold mask. Repeated identical checks must report ok with no restart, and the all-ones status must leave the mode untouched.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
   typedef enum logic [1:0] {
      LS_OK      = 2'd0,
      LS_CHANGED = 2'd1,
      LS_NOLINK  = 2'd2,
      LS_MISSING = 2'd3
   } lnk_code_e;

   typedef struct packed {
      logic fdx;
      logic thr;
   } mode_t;
endpackage

// File: rtl/ldr_resolve.sv
module ldr_resolve
   import ldr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int FD10_BIT  = 6,
   parameter int HD100_BIT = 7,
   parameter int FD100_BIT = 8,
   parameter int T4_BIT    = 9
) (
   input  logic [DATA_W-1:0] part_word,
   input  logic [DATA_W-1:0] adv_word,
   input  logic              lock,
   input  mode_t             cur_mode,
   output mode_t             new_mode,
   output logic              differs
);
   localparam logic [DATA_W-1:0] FAST_MASK = (DATA_W'(1) << HD100_BIT) |
                                             (DATA_W'(1) << FD100_BIT) |
                                             (DATA_W'(1) << T4_BIT);

   if (T4_BIT >= DATA_W || FD100_BIT >= DATA_W) begin : g_bad_bits
      $error("ability bit outside data word");
   end

   logic [DATA_W-1:0] neg;
   logic              fdx_neg;

   always_comb begin
      neg          = part_word & adv_word;
      fdx_neg      = neg[FD100_BIT] | (neg[FD10_BIT] & ~neg[HD100_BIT]);
      new_mode.thr = ((neg & FAST_MASK) == '0);
      new_mode.fdx = lock | fdx_neg;
      differs      = (new_mode != cur_mode);
   end
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq #(
   parameter int DATA_W    = 16,
   parameter int AW        = 5,
   parameter int STAT_ADDR = 1,
   parameter int PART_ADDR = 5,
   parameter int LINK_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   output logic [AW-1:0]     req_reg,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              fin,
   output logic              fin_res,
   output logic              fin_missing,
   output logic [DATA_W-1:0] part_q
);
   typedef enum logic [2:0] {S_IDLE, S_RD1, S_RDP, S_EVAL, S_RD2} st_e;

   if (LINK_BIT >= DATA_W || STAT_ADDR >= (1 << AW) || PART_ADDR >= (1 << AW)) begin : g_bad_cfg
      $error("sequencer parameters out of range");
   end

   st_e               st, st_n;
   logic [DATA_W-1:0] st1_q;

   always_comb begin
      st_n        = st;
      req_valid   = 1'b0;
      req_reg     = AW'(STAT_ADDR);
      fin         = 1'b0;
      fin_res     = 1'b0;
      fin_missing = 1'b0;
      case (st)
         S_IDLE: if (start) st_n = S_RD1;
         S_RD1: begin
            req_valid = 1'b1;
            if (rsp_valid) st_n = S_RDP;
         end
         S_RDP: begin
            req_valid = 1'b1;
            req_reg   = AW'(PART_ADDR);
            if (rsp_valid) st_n = S_EVAL;
         end
         S_EVAL: begin
            if (&st1_q) begin
               fin         = 1'b1;
               fin_missing = 1'b1;
               st_n        = S_IDLE;
            end else if (!st1_q[LINK_BIT]) begin
               st_n = S_RD2;
            end else begin
               fin     = 1'b1;
               fin_res = 1'b1;
               st_n    = S_IDLE;
            end
         end
         S_RD2: begin
            req_valid = 1'b1;
            if (rsp_valid) begin
               fin     = 1'b1;
               fin_res = rsp_data[LINK_BIT];
               st_n    = S_IDLE;
            end
         end
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         st1_q  <= '0;
         part_q <= '0;
      end else begin
         st <= st_n;
         if (st == S_RD1 && rsp_valid) st1_q  <= rsp_data;
         if (st == S_RDP && rsp_valid) part_q <= rsp_data;
      end
   end

   // R2: request address is always one of the two registers
   a_r2_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_reg == AW'(STAT_ADDR) || req_reg == AW'(PART_ADDR)));
   // R2: an unanswered request is held steady
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> (req_valid && $stable(req_reg)));
endmodule

// File: rtl/ldr_link_check.sv
module ldr_link_check
   import ldr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int AW        = 5,
   parameter int STAT_ADDR = 1,
   parameter int PART_ADDR = 5,
   parameter int LINK_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] adv_word,
   input  logic              dplx_lock,
   output logic              req_valid,
   output logic [AW-1:0]     req_reg,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              done,
   output logic [1:0]        status,
   output logic              mode_fdx,
   output logic              mode_thr,
   output logic              restart
);
   logic              fin, fin_res, fin_missing, differs;
   logic [DATA_W-1:0] part_q;
   mode_t             mode_q, mode_n;
   lnk_code_e         code_q;

   ldr_seq #(.DATA_W(DATA_W), .AW(AW), .STAT_ADDR(STAT_ADDR),
             .PART_ADDR(PART_ADDR), .LINK_BIT(LINK_BIT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(req_valid), .req_reg(req_reg),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .fin(fin), .fin_res(fin_res), .fin_missing(fin_missing), .part_q(part_q)
   );

   ldr_resolve #(.DATA_W(DATA_W)) u_res (
      .part_word(part_q), .adv_word(adv_word), .lock(dplx_lock),
      .cur_mode(mode_q), .new_mode(mode_n), .differs(differs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         code_q  <= LS_OK;
         done    <= 1'b0;
         restart <= 1'b0;
      end else begin
         done    <= fin;
         restart <= fin && fin_res && differs;
         if (fin) begin
            if (fin_missing)   code_q <= LS_MISSING;
            else if (!fin_res) code_q <= LS_NOLINK;
            else if (differs)  code_q <= LS_CHANGED;
            else               code_q <= LS_OK;
         end
         if (fin && fin_res && differs) mode_q <= mode_n;
      end
   end

   assign status   = code_q;
   assign mode_fdx = mode_q.fdx;
   assign mode_thr = mode_q.thr;

   // R8: restart only in a done cycle that reports a change
   a_r8_restart_with_change: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (done && status == LS_CHANGED));
   // R8: the mode only moves together with a change report
   a_r8_mode_moves_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> (done && status == LS_CHANGED));
   // R3: missing transceiver leaves the mode alone
   a_r3_missing_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == LS_MISSING) |-> ($stable(mode_q) && !restart));
   // R9: done lasts one cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/sim_ldr_link_check.sv
module sim_ldr_link_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] adv_word = '0;
   logic        dplx_lock = 1'b0;
   logic        req_valid;
   logic [4:0]  req_reg;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic        done, mode_fdx, mode_thr, restart;
   logic [1:0]  status;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ldr_link_check u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .adv_word(adv_word),
      .dplx_lock(dplx_lock), .req_valid(req_valid), .req_reg(req_reg),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done),
      .status(status), .mode_fdx(mode_fdx), .mode_thr(mode_thr),
      .restart(restart)
   );

   // transceiver model
   logic        clr = 1'b1;
   logic [15:0] sta = '0, stb = '0, lpa = '0;
   int          nst, wcnt, nserved, ndone;
   logic [4:0]  served0, served1;

   always @(posedge clk) begin
      if (clr) begin
         nst <= 0; wcnt <= 0; nserved <= 0; ndone <= 0;
         rsp_valid <= 1'b0; rsp_data <= '0;
         served0 <= '0; served1 <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (done) ndone <= ndone + 1;
         if (req_valid && !rsp_valid) begin
            if (wcnt == 2) begin
               wcnt      <= 0;
               rsp_valid <= 1'b1;
               nserved   <= nserved + 1;
               if (nserved == 0) served0 <= req_reg;
               if (nserved == 1) served1 <= req_reg;
               if (req_reg == 5'd1) begin
                  rsp_data <= (nst == 0) ? sta : stb;
                  nst      <= nst + 1;
               end else begin
                  rsp_data <= lpa;
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end
      end
   end

   typedef struct packed {
      logic        lock;
      logic [15:0] adv;
      logic [15:0] sa;
      logic [15:0] sb;
      logic [15:0] lp;
      logic [1:0]  code;
      logic        fdx;
      logic        thr;
      logic [1:0]  reads;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{1'b0, 16'h01E1, 16'h782D, 16'h782D, 16'h01E1, 2'd1, 1'b1, 1'b0, 2'd1}, // R6 R7 100 full
      '{1'b0, 16'h01E1, 16'h782D, 16'h782D, 16'h01E1, 2'd0, 1'b1, 1'b0, 2'd1}, // R8 unchanged
      '{1'b0, 16'h01E1, 16'hFFFF, 16'h782D, 16'h0021, 2'd3, 1'b1, 1'b0, 2'd1}, // R3 missing
      '{1'b0, 16'h01E1, 16'h7809, 16'h7809, 16'h0021, 2'd2, 1'b1, 1'b0, 2'd2}, // R4 no link
      '{1'b0, 16'h01E1, 16'h7809, 16'h782D, 16'h0061, 2'd1, 1'b1, 1'b1, 2'd2}, // R5 recover, 10 full
      '{1'b0, 16'h01E1, 16'h782D, 16'h782D, 16'h00E1, 2'd1, 1'b0, 1'b0, 2'd1}, // R7 10 full + 100 half
      '{1'b1, 16'h01E1, 16'h782D, 16'h782D, 16'h00E1, 2'd1, 1'b1, 1'b0, 2'd1}, // R7 lock
      '{1'b0, 16'h0021, 16'h782D, 16'h782D, 16'h01E1, 2'd1, 1'b0, 1'b1, 2'd1}, // R6 masked by adv
      '{1'b0, 16'h0021, 16'h782D, 16'h782D, 16'h01E1, 2'd0, 1'b0, 1'b1, 2'd1}, // R8 ok
      '{1'b0, 16'h0201, 16'h782D, 16'h782D, 16'h0200, 2'd1, 1'b0, 1'b0, 2'd1}  // R6 T4 only
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (done) begin seen = 1'b1; break; end
      end
   endtask

   bit seen;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clr   = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(mode_fdx == 1'b0 && mode_thr == 1'b0, "R1 mode", {mode_fdx, mode_thr}, 0);
      check(!done && !restart && !req_valid, "R1 outputs", {done, restart, req_valid}, 0);

      for (int i = 0; i < NV; i++) begin
         clear_model();
         dplx_lock = VT[i].lock; adv_word = VT[i].adv;
         sta = VT[i].sa; stb = VT[i].sb; lpa = VT[i].lp;
         start = 1'b1; @(negedge clk); start = 1'b0;
         wait_done(seen);
         check(seen, "R9 done seen", int'(seen), 1);
         check(status == VT[i].code, "R3/R4/R8 status code", status, VT[i].code);
         check(mode_fdx == VT[i].fdx, "R7 fdx", mode_fdx, VT[i].fdx);
         check(mode_thr == VT[i].thr, "R6 thr", mode_thr, VT[i].thr);
         check(restart == (VT[i].code == 2'd1), "R8 restart", restart, int'(VT[i].code == 2'd1));
         @(negedge clk);
         check(nst == int'(VT[i].reads), "R4 status reads", nst, VT[i].reads);
         check(!done, "R9 done one cycle", done, 0);
         if (i == 0) begin
            check(served0 == 5'd1 && served1 == 5'd5, "R2 read order",
                  {served0, served1}, {5'd1, 5'd5});
         end
      end

      // R9 start while busy is ignored; mode (0,0) -> (0,1)
      clear_model();
      dplx_lock = 1'b0; adv_word = 16'h0021;
      sta = 16'h782D; stb = 16'h782D; lpa = 16'h0021;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      check(ndone == 1, "R9 busy start ignored (done count)", ndone, 1);
      check(nst == 1, "R9 busy start ignored (reads)", nst, 1);
      check(mode_thr == 1'b1 && mode_fdx == 1'b0, "R6 busy-case mode", {mode_fdx, mode_thr}, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule